// File: doc/BRIEF.md
# Coherent Read-Modify-Write Counter Bank

This block keeps a bank of counters in synchronous RAM that can map onto block memory. In any cycle a client may present one update, made of an address and an increment. The bank reads the stored count, adds the increment and writes the new value back to the same address. It sustains one update per clock with no stall, even when the same counter is hit on every cycle.

The write enable and write address are delayed to match the read latency of the memory. That latency, L, is 2 when the memory output is registered and 1 when it is not. The memory model itself supplies a coherent read: a read that meets a write still in flight returns the newer value. No separate cache of recent writes is needed.

A second, read-only port returns a counter value a fixed number of cycles after a query. A one-pulse clear request starts a sweep that writes zero to every address, one address per clock. Overflow wraps modulo 2^CW by default; a parameter selects saturation at the all-ones value instead. Counter contents are undefined after reset until the first sweep completes.

Top module: `rmw_counter_bank`

## Requirements
- R1: An update accepted in cycle T is written to the array at the clock edge that ends cycle T+L, where L is 2 with REG_OUT=1 and 1 with REG_OUT=0. This gives one write per accepted update with no stall.
- R2: Updates to the same address in consecutive cycles each build on every earlier accepted update, so a burst of N updates adds all N increments.
- R3: With OVF=OVF_WRAP (value 0), the stored result is (old + increment) mod 2^CW.
- R4: With OVF=OVF_SAT (value 1), the stored result is min(old + increment, 2^CW - 1).
- R5: A query sampled with qry_valid high in cycle Q produces a one-cycle qry_ack pulse in cycle Q+L+1, and at no other time.
- R6: The qry_data delivered with qry_ack holds the counter value after every update accepted before cycle Q. An update accepted in cycle Q itself is not included.
- R7: A clr_start pulse seen while idle raises clr_busy from the next cycle for exactly 2^AW cycles. During the sweep, every address is written with zero in ascending order. Once clr_busy falls, every counter reads zero apart from updates accepted afterwards. A clr_start pulse while clr_busy is high is ignored and does not lengthen the sweep.
- R8: An update presented in a cycle where clr_busy is high is dropped and leaves every counter unchanged.
- R9: During and directly after reset, clr_busy and qry_ack are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all reads and writes |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update request present this cycle |
| upd_addr | input | AW | Counter to update |
| upd_inc | input | IW | Amount to add (IW <= CW) |
| clr_start | input | 1 | Pulse to start a zeroing sweep |
| clr_busy | output | 1 | Sweep in progress; updates are dropped |
| qry_valid | input | 1 | Query request present this cycle |
| qry_addr | input | AW | Counter to read |
| qry_ack | output | 1 | Query result valid |
| qry_data | output | CW | Counter value for the query |

## Verification
The assertions assume that reset is high from time zero and that every input is at a known level once reset falls. They also assume that upd_inc is never wider than the counter. The stimulus drives only defined values on every cycle after reset. It starts with a clear sweep, so no checked query ever reads contents from before the first sweep. Queries are issued only while clr_busy is low, because a query during a sweep returns a mix of cleared and uncleared words that the reference does not model. The stimulus focuses updates on a handful of addresses, so same-address hazards at distances 1, 2 and 3 occur often in both latency settings.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  // Overflow handling selected per instance.
  typedef enum logic {
    OVF_WRAP = 1'b0,
    OVF_SAT  = 1'b1
  } ovf_mode_e;

  // Read latency of the RAM in cycles: one for the array register,
  // plus one when the output register is enabled.
  function automatic int unsigned read_latency(input bit reg_out);
    return reg_out ? 2 : 1;
  endfunction

endpackage

// File: rtl/rmw_delay_line.sv
module rmw_delay_line #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/rmw_coherent_ram.sv
module rmw_coherent_ram
  import rmw_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned DW      = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LAT   = read_latency(REG_OUT);

  // Storage: single write port, no reset, inferable as block RAM.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  // Record of the writes made at the last LAT edges. A read issued LAT
  // cycles ago cannot have seen these, so they override the array data.
  logic [LAT-1:0] hist_v;
  logic [AW-1:0]  hist_a [LAT];
  logic [DW-1:0]  hist_d [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_v <= '0;
    end else begin
      hist_v[0] <= we;
      for (int i = 1; i < LAT; i++) hist_v[i] <= hist_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    hist_a[0] <= wr_addr;
    hist_d[0] <= wr_data;
    for (int i = 1; i < LAT; i++) begin
      hist_a[i] <= hist_a[i-1];
      hist_d[i] <= hist_d[i-1];
    end
  end

  logic [1:0][AW-1:0] raddr;
  assign raddr = {rd_addr_b, rd_addr_a};

  for (genvar g = 0; g < 2; g++) begin : g_port
    logic [DW-1:0] raw_q;
    logic [DW-1:0] dout;
    logic [AW-1:0] addr_l;
    logic [DW-1:0] fwd;

    always_ff @(posedge clk) raw_q <= mem[raddr[g]];

    if (REG_OUT) begin : g_oreg
      logic [DW-1:0] oreg_q;
      always_ff @(posedge clk) oreg_q <= raw_q;
      assign dout = oreg_q;
    end else begin : g_noreg
      assign dout = raw_q;
    end

    rmw_delay_line #(.WIDTH(AW), .STAGES(LAT)) u_addr_line (
      .clk (clk),
      .rst (rst),
      .d   (raddr[g]),
      .q   (addr_l)
    );

    // Oldest first, so the newest matching write wins.
    always_comb begin
      fwd = dout;
      for (int k = int'(LAT) - 1; k >= 0; k--) begin
        if (hist_v[k] && hist_a[k] == addr_l) fwd = hist_d[k];
      end
    end

    if (g == 0) begin : g_out_a
      assign rd_data_a = fwd;
    end else begin : g_out_b
      assign rd_data_b = fwd;
    end
  end

endmodule

// File: rtl/rmw_clear_seq.sv
module rmw_clear_seq #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        addr <= '0;
      end
    end else begin
      addr <= addr + AW'(1);
      if (addr == LAST) busy <= 1'b0;
    end
  end

  // R7: the sweep only begins in response to a start pulse
  a_r7_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R7: addresses step by one through the sweep
  a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (addr == AW'($past(addr) + AW'(1))));

  // R7: the sweep stops right after the last address
  a_r7_stop_at_end: assert property (@(posedge clk) disable iff (rst)
    (busy && addr == LAST) |=> !busy);

endmodule

// File: rtl/rmw_counter_bank.sv
module rmw_counter_bank
  import rmw_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned CW      = 8,
  parameter int unsigned IW      = 4,
  parameter bit          REG_OUT = 1'b1,
  parameter ovf_mode_e   OVF     = OVF_WRAP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_addr,
  input  logic [IW-1:0] upd_inc,
  input  logic          clr_start,
  output logic          clr_busy,
  input  logic          qry_valid,
  input  logic [AW-1:0] qry_addr,
  output logic          qry_ack,
  output logic [CW-1:0] qry_data
);

  localparam int unsigned LAT = read_latency(REG_OUT);

  typedef struct packed {
    logic          clr;
    logic [AW-1:0] addr;
    logic [IW-1:0] inc;
  } op_t;

  localparam int unsigned OPW = $bits(op_t) + 1;

  // Operation entering the pipeline: a sweep step or a client update
  logic          in_vld;
  op_t           in_op;
  logic          wr_vld;
  op_t           wr_op;
  logic [AW-1:0] sweep_addr;

  rmw_clear_seq #(.AW(AW)) u_clear (
    .clk   (clk),
    .rst   (rst),
    .start (clr_start),
    .busy  (clr_busy),
    .addr  (sweep_addr)
  );

  always_comb begin
    in_vld     = !rst && (clr_busy || upd_valid);
    in_op.clr  = clr_busy;
    in_op.addr = clr_busy ? sweep_addr : upd_addr;
    in_op.inc  = clr_busy ? '0 : upd_inc;
  end

  // Write enable and address retimed to meet the read data
  rmw_delay_line #(.WIDTH(OPW), .STAGES(LAT)) u_op_line (
    .clk (clk),
    .rst (rst),
    .d   ({in_vld, in_op}),
    .q   ({wr_vld, wr_op})
  );

  logic [CW-1:0] old_val;
  logic [CW-1:0] new_val;
  logic [CW-1:0] wr_data;
  logic [CW:0]   sum_ext;
  logic [CW-1:0] qry_rd;

  always_comb begin
    sum_ext = {1'b0, old_val} + {{(CW + 1 - IW){1'b0}}, wr_op.inc};
    if (OVF == OVF_SAT && sum_ext[CW]) new_val = '1;
    else                               new_val = sum_ext[CW-1:0];
    wr_data = wr_op.clr ? '0 : new_val;
  end

  rmw_coherent_ram #(.AW(AW), .DW(CW), .REG_OUT(REG_OUT)) u_ram (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_vld),
    .wr_addr   (wr_op.addr),
    .wr_data   (wr_data),
    .rd_addr_a (in_op.addr),
    .rd_addr_b (qry_addr),
    .rd_data_a (old_val),
    .rd_data_b (qry_rd)
  );

  // Query path: the RAM latency plus one output register
  logic q_in;
  logic q_lat;

  assign q_in = qry_valid && !rst;

  rmw_delay_line #(.WIDTH(1), .STAGES(LAT)) u_qry_line (
    .clk (clk),
    .rst (rst),
    .d   (q_in),
    .q   (q_lat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_ack  <= 1'b0;
      qry_data <= '0;
    end else begin
      qry_ack  <= q_lat;
      qry_data <= qry_rd;
    end
  end

  // R1: a write lands exactly LAT cycles after the operation entered
  a_r1_write_timing: assert property (@(posedge clk) disable iff (rst)
    wr_vld == $past(in_vld, LAT));

  // R4: saturation never lets a counter fall through an update
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (OVF == OVF_SAT && wr_vld && !wr_op.clr) |-> (wr_data >= old_val));

  // R5: acknowledge follows the query by LAT+1 cycles
  a_r5_ack_latency: assert property (@(posedge clk) disable iff (rst)
    qry_ack == $past(q_in, LAT + 1));

  // R8: writes from cycles in which a sweep ran are all sweep writes
  a_r8_refused_in_sweep: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_busy, LAT) && wr_vld) |-> wr_op.clr);

endmodule

// File: tb/test_rmw_counter_bank.sv
module test_rmw_counter_bank;
  import rmw_pkg::*;

  localparam int AW    = 4;
  localparam int CW    = 6;
  localparam int IW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 1'b0;
  logic [AW-1:0] upd_addr = '0;
  logic [IW-1:0] upd_inc = '0;
  logic clr_start = 1'b0;
  logic qry_valid = 1'b0;
  logic [AW-1:0] qry_addr = '0;

  logic busy_r, busy_u, busy_s;
  logic ack_r, ack_u, ack_s;
  logic [CW-1:0] dat_r, dat_u, dat_s;

  always #4 clk = ~clk;

  rmw_counter_bank #(.AW(AW), .CW(CW), .IW(IW), .REG_OUT(1'b1), .OVF(OVF_WRAP)) i_rmw_counter_bank (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_inc(upd_inc),
    .clr_start(clr_start), .clr_busy(busy_r), .qry_valid(qry_valid), .qry_addr(qry_addr),
    .qry_ack(ack_r), .qry_data(dat_r));

  rmw_counter_bank #(.AW(AW), .CW(CW), .IW(IW), .REG_OUT(1'b0), .OVF(OVF_WRAP)) i_rmw_counter_bank_u (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_inc(upd_inc),
    .clr_start(clr_start), .clr_busy(busy_u), .qry_valid(qry_valid), .qry_addr(qry_addr),
    .qry_ack(ack_u), .qry_data(dat_u));

  rmw_counter_bank #(.AW(AW), .CW(CW), .IW(IW), .REG_OUT(1'b1), .OVF(OVF_SAT)) i_rmw_counter_bank_s (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_inc(upd_inc),
    .clr_start(clr_start), .clr_busy(busy_s), .qry_valid(qry_valid), .qry_addr(qry_addr),
    .qry_ack(ack_s), .qry_data(dat_s));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  int ref_w [DEPTH];
  int ref_s [DEPTH];
  int clr_lo = 1;
  int clr_hi = 0;
  string tag = "R6";

  int qc [$];
  int qw [$];
  int qs [$];
  string qt [$];
  int ptr_r = 0;
  int ptr_u = 0;
  int ptr_s = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit exp_busy();
    return (cyc >= clr_lo) && (cyc <= clr_hi);
  endfunction

  // One acknowledge seen on an instance with read latency lat
  task automatic take_ack(input string who, input int lat, input int idx, input int got, input bit sat);
    if (idx >= qc.size()) begin
      chk(1'b0, "R5", {who, " ack without query"}, 1, 0);
    end else begin
      chk(cyc == qc[idx] + 1 + lat, "R5", {who, " ack cycle"}, cyc, qc[idx] + 1 + lat);
      if (sat) chk(got == qs[idx], "R4", {who, " saturated value"}, got, qs[idx]);
      else     chk(got == qw[idx], qt[idx], {who, " counter value"}, got, qw[idx]);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy_r == exp_busy(), "R7", "busy (reg)", int'(busy_r), int'(exp_busy()));
      chk(busy_u == exp_busy(), "R7", "busy (unreg)", int'(busy_u), int'(exp_busy()));
      chk(busy_s == exp_busy(), "R7", "busy (sat)", int'(busy_s), int'(exp_busy()));
      if (ack_u) begin take_ack("unreg", 1, ptr_u, int'(dat_u), 1'b0); ptr_u++; end
      if (ack_r) begin take_ack("reg", 2, ptr_r, int'(dat_r), 1'b0); ptr_r++; end
      if (ack_s) begin take_ack("sat", 2, ptr_s, int'(dat_s), 1'b1); ptr_s++; end
    end
  end

  // Drive one cycle of stimulus and advance the reference in step
  task automatic drive(input bit uv, input int ua, input int ui, input bit qv, input int qa, input bit cs);
    bit b;
    @(negedge clk);
    b = exp_busy();
    upd_valid = uv;
    upd_addr  = AW'(ua);
    upd_inc   = IW'(ui);
    clr_start = cs;
    qry_addr  = AW'(qa);
    qry_valid = qv && !b;
    if (qv && !b) begin
      qc.push_back(cyc);
      qw.push_back(ref_w[qa]);
      qs.push_back(ref_s[qa]);
      qt.push_back(tag);
    end
    if (uv && !b) begin
      ref_w[ua] = (ref_w[ua] + ui) % (CMAX + 1);
      ref_s[ua] = (ref_s[ua] + ui > CMAX) ? CMAX : ref_s[ua] + ui;
    end
    if (cs && !b) begin
      clr_lo = cyc + 1;
      clr_hi = cyc + DEPTH;
      for (int i = 0; i < DEPTH; i++) begin ref_w[i] = 0; ref_s[i] = 0; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b0, 0, 1'b0);
  endtask

  task automatic query_all(input string t);
    tag = t;
    for (int a = 0; a < DEPTH; a++) drive(1'b0, 0, 0, 1'b1, a, 1'b0);
    idle(5);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", "run did not finish", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin ref_w[i] = 0; ref_s[i] = 0; end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk(busy_r == 1'b0 && busy_u == 1'b0 && busy_s == 1'b0, "R9", "busy after reset", int'(busy_r | busy_u | busy_s), 0);
    chk(ack_r == 1'b0 && ack_u == 1'b0 && ack_s == 1'b0, "R9", "ack after reset", int'(ack_r | ack_u | ack_s), 0);

    // R7 and R8: sweep while updates hammer the bank
    drive(1'b0, 0, 0, 1'b0, 0, 1'b1);
    for (int i = 0; i < DEPTH; i++) drive(1'b1, i, 15, 1'b0, 0, 1'b0);
    idle(4);
    query_all("R8");

    // R1 and R2: back-to-back hits on one address with queries each cycle
    tag = "R1/R2";
    for (int i = 0; i < 40; i++) drive(1'b1, 5, (i % 15) + 1, 1'b1, 5, 1'b0);
    for (int i = 0; i < 30; i++) drive(1'b1, i % 2 ? 6 : 7, i % 16, 1'b1, i % 3 ? 6 : 7, 1'b0);
    idle(4);

    // R3, R4, R6: random hot-spot traffic, including hazards at every distance
    tag = "R3";
    for (int i = 0; i < 2500; i++) begin
      int ua = ($urandom % 8 == 0) ? int'($urandom % DEPTH) : int'($urandom % 4);
      int qa = ($urandom % 8 == 0) ? int'($urandom % DEPTH) : int'($urandom % 4);
      drive($urandom % 4 != 0, ua, int'($urandom % 16), $urandom % 2 == 1, qa, $urandom % 400 == 0);
    end
    idle(DEPTH + 4);
    query_all("R6");

    // R7: a second start pulse during the sweep is ignored
    for (int i = 0; i < 4; i++) drive(1'b1, i, 9, 1'b0, 0, 1'b0);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b1);
    idle(6);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b1);
    idle(DEPTH);
    query_all("R7");

    // R6: an update in the same cycle as a query is excluded from it
    tag = "R6";
    drive(1'b1, 2, 7, 1'b1, 2, 1'b0);
    drive(1'b0, 0, 0, 1'b1, 2, 1'b0);
    idle(6);

    chk(ptr_r == qc.size(), "R5", "acks (reg)", ptr_r, qc.size());
    chk(ptr_u == qc.size(), "R5", "acks (unreg)", ptr_u, qc.size());
    chk(ptr_s == qc.size(), "R5", "acks (sat)", ptr_s, qc.size());
    done = 1;
    summary();
    $finish;
  end

endmodule